// File: doc/BRIEF.md
# DMA Fault Capture and Interrupt Logger

This block sits beside a DMA address filter and takes the fault events that the filter reports. When logging is enabled and no fault is already held, it freezes a full snapshot of the first faulting request. The snapshot holds the fault code, the source identifier, the 48-bit address, the byte count, the route and privilege identifiers, and six access-property flags. It then raises a level interrupt. Software reads the snapshot through a small word-indexed register port and writes the acknowledge register. That write releases the snapshot, drops the interrupt and re-arms the logger.

While a snapshot is held, later faults do not touch it. A saturating counter tells software how many faults were lost before it acknowledged.

Register indices on `reg_addr`:

| Index | Contents |
|-------|----------|
| 0 | enable flag, bit 0, read/write |
| 1 | acknowledge, write-only, reads 0 |
| 2 | source ID in [15:0], fault code in [23:16] |
| 3 | address bits [31:0] |
| 4 | address bits [47:32] in [15:0] |
| 5 | property flags in [5:0], privilege ID in [15:8], route ID in [27:16] |
| 6 | byte count in [9:0] |
| 7 | held flag in bit 0, drop count from bit 16 |

The property flags are ordered from bit 0 as follows: secure, privileged, cacheable, debug, read, write.

Top module: `dma_fault_logger`

## Requirements
- R1: After a synchronous active-low reset, `irq` is 0, the enable flag is 0, and every readable register (indices 0 to 7) reads 0.
- R2: Bit 0 of register index 0 is the enable flag. It is written by a write to index 0 and read back at index 0. While it is 0, a fault on `flt_valid` is neither captured nor counted, and `irq` stays 0.
- R3: With the enable flag set and no fault held, a fault sampled at a clock edge is stored and `irq` is 1 after that edge. The stored fields read back exactly as presented: the code (8 bits) in index 2 [23:16] and the source ID (16 bits) in index 2 [15:0]. The address low word is index 3. The address high 16 bits are index 4 [15:0]. Index 5 holds the flags [5:0], the privilege ID [15:8] and the route ID [27:16]. Index 6 [9:0] holds the byte count. Every code value, including 0 (miss) and 6 (prefetch violation), is stored unchanged.
- R4: While a fault is held and not acknowledged, later faults leave indices 2 to 6 unchanged and `irq` stays 1.
- R5: Each enabled fault that arrives while one is held, in a cycle with no acknowledge, adds one to the drop count in index 7 [16+OVF_W-1:16]. The count stops at 2^OVF_W-1. Index 7 bit 0 shows the held flag.
- R6: `irq` is level-high from capture until an acknowledge (any write to index 1). After the edge that samples the acknowledge, `irq` is 0, the held flag is 0 and the drop count is 0. The stored fields keep their values.
- R7: A fault that arrives in the same cycle as an acknowledge, with the enable flag set, is captured as a fresh snapshot. After that edge, `irq` is 1 and the drop count is 0.
- R8: Index 1 always reads 0. Writes to indices 1 to 7 change no readable field other than what R6 defines for index 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| flt_valid | input | 1 | fault event strobe, one per cycle |
| flt_code | input | 8 | fault code |
| flt_src | input | 16 | source identifier |
| flt_addr | input | 48 | faulting address |
| flt_bytes | input | 10 | byte count of the request |
| flt_route | input | 12 | route identifier |
| flt_priv | input | 8 | privilege identifier |
| flt_props | input | 6 | access property flags |
| reg_addr | input | 3 | register index |
| reg_wr | input | 1 | write strobe |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for `reg_addr`, combinational |
| irq | output | 1 | level fault interrupt |

## Verification
The bench targets four corner cases.

- A fault that lands in the same cycle as the acknowledge. A design that gave the acknowledge priority over the new fault would lose that fault and leave `irq` low.
- A long burst of faults while a fault is held. A counter that wraps instead of stopping would read back a small number after 2^OVF_W drops.
- Faults while the enable flag is clear. A design that checks the enable only for the interrupt, and not for the counter or the capture, would show a changed log or a non-zero count.
- Writes to the read-only indices during random traffic. These would expose any field that shares a write path, and any snapshot that a held fault fails to protect.

// File: rtl/dfl_pkg.sv
// Package: field widths, register indices and the fault record type for the
// DMA fault logger. Assumes a 32-bit register data path.
package dfl_pkg;
    localparam int CODE_W  = 8;
    localparam int SRC_W   = 16;
    localparam int FADDR_W = 48;
    localparam int BCNT_W  = 10;
    localparam int ROUTE_W = 12;
    localparam int PRIV_W  = 8;
    localparam int PROP_W  = 6;
    localparam int DATA_W  = 32;
    localparam int RIDX_W  = 3;

    localparam logic [RIDX_W-1:0] IDX_CTRL  = 3'd0;
    localparam logic [RIDX_W-1:0] IDX_ACK   = 3'd1;
    localparam logic [RIDX_W-1:0] IDX_HDR   = 3'd2;
    localparam logic [RIDX_W-1:0] IDX_ADLO  = 3'd3;
    localparam logic [RIDX_W-1:0] IDX_ADHI  = 3'd4;
    localparam logic [RIDX_W-1:0] IDX_ATTR  = 3'd5;
    localparam logic [RIDX_W-1:0] IDX_BYTES = 3'd6;
    localparam logic [RIDX_W-1:0] IDX_STAT  = 3'd7;

    typedef struct packed {
        logic [CODE_W-1:0]  code;
        logic [SRC_W-1:0]   src;
        logic [FADDR_W-1:0] addr;
        logic [BCNT_W-1:0]  bytes;
        logic [ROUTE_W-1:0] route;
        logic [PRIV_W-1:0]  priv;
        logic [PROP_W-1:0]  props;
    } fault_rec_t;
endpackage

// File: rtl/dfl_capture.sv
// Capture stage: freezes the first enabled fault into a record and keeps it
// until an acknowledge. A fault in the acknowledge cycle is taken as fresh.
// Assumes at most one fault event per cycle.
module dfl_capture
    import dfl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       ack,
    input  logic       flt_valid,
    input  fault_rec_t flt_in,
    output logic       held,
    output fault_rec_t rec_q,
    output logic       drop
);
    logic take;

    // Decide whether this cycle's fault is stored or dropped.
    always_comb begin
        take = flt_valid && en && (!held || ack);
        drop = flt_valid && en && held && !ack;
    end

    // Hold flag and snapshot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= 1'b0;
            rec_q <= '0;
        end else if (take) begin
            held  <= 1'b1;
            rec_q <= flt_in;
        end else if (ack) begin
            held  <= 1'b0;
        end
    end
endmodule

// File: rtl/dfl_drop_counter.sv
// Drop counter: counts faults lost while a snapshot is held, stopping at the
// all-ones value. Clear has priority over increment.
module dfl_drop_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Saturating count with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dfl_regs.sv
// Register port: holds the enable flag, decodes the acknowledge write and
// multiplexes the snapshot onto the read bus. Reads are combinational.
// Assumes CNT_W <= 16.
module dfl_regs
    import dfl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  fault_rec_t        rec,
    input  logic              held,
    input  logic [CNT_W-1:0]  drops,
    output logic              en,
    output logic              ack,
    output logic [DATA_W-1:0] reg_rdata
);
    // Acknowledge pulse for any write to the acknowledge index.
    assign ack = reg_wr && (reg_addr == IDX_ACK);

    // Enable flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else if (reg_wr && reg_addr == IDX_CTRL) begin
            en <= reg_wdata[0];
        end
    end

    // Read data selection.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_CTRL:  reg_rdata[0] = en;
            IDX_HDR: begin
                reg_rdata[SRC_W-1:0]        = rec.src;
                reg_rdata[16 +: CODE_W]     = rec.code;
            end
            IDX_ADLO:  reg_rdata = rec.addr[31:0];
            IDX_ADHI:  reg_rdata[FADDR_W-33:0] = rec.addr[FADDR_W-1:32];
            IDX_ATTR: begin
                reg_rdata[PROP_W-1:0]       = rec.props;
                reg_rdata[8 +: PRIV_W]      = rec.priv;
                reg_rdata[16 +: ROUTE_W]    = rec.route;
            end
            IDX_BYTES: reg_rdata[BCNT_W-1:0] = rec.bytes;
            IDX_STAT: begin
                reg_rdata[0]                = held;
                reg_rdata[16 +: CNT_W]      = drops;
            end
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_fault_logger.sv
// Top: DMA fault capture and interrupt logger. Connects capture stage, drop
// counter and register port. irq follows the held flag directly.
// Assumes a single clock domain and synchronous active-low reset.
module dma_fault_logger
    import dfl_pkg::*;
#(
    parameter int OVF_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flt_valid,
    input  logic [7:0]  flt_code,
    input  logic [15:0] flt_src,
    input  logic [47:0] flt_addr,
    input  logic [9:0]  flt_bytes,
    input  logic [11:0] flt_route,
    input  logic [7:0]  flt_priv,
    input  logic [5:0]  flt_props,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    fault_rec_t       flt_rec;
    fault_rec_t       rec_q;
    logic             held;
    logic             drop;
    logic             en_q;
    logic             ack;
    logic [OVF_W-1:0] ovf_cnt;

    // Pack incoming fault fields into one record.
    always_comb begin
        flt_rec.code  = flt_code;
        flt_rec.src   = flt_src;
        flt_rec.addr  = flt_addr;
        flt_rec.bytes = flt_bytes;
        flt_rec.route = flt_route;
        flt_rec.priv  = flt_priv;
        flt_rec.props = flt_props;
    end

    dfl_capture u_cap (
        .clk(clk), .rst_n(rst_n), .en(en_q), .ack(ack),
        .flt_valid(flt_valid), .flt_in(flt_rec),
        .held(held), .rec_q(rec_q), .drop(drop)
    );

    dfl_drop_counter #(.W(OVF_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(ack), .inc(drop), .count(ovf_cnt)
    );

    dfl_regs #(.CNT_W(OVF_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .rec(rec_q), .held(held), .drops(ovf_cnt),
        .en(en_q), .ack(ack), .reg_rdata(reg_rdata)
    );

    assign irq = held;
endmodule

// File: rtl/dfl_checker.sv
// Checker: temporal properties of the fault logger, bound to the top module.
module dfl_checker
    import dfl_pkg::*;
#(
    parameter int OVF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flt_valid,
    input logic [47:0]      flt_addr,
    input logic [2:0]       reg_addr,
    input logic             reg_wr,
    input logic             irq,
    input logic             en,
    input logic [OVF_W-1:0] ovf,
    input fault_rec_t       rec
);
    localparam logic [OVF_W-1:0] MAXV = {OVF_W{1'b1}};
    logic ack_w;
    assign ack_w = reg_wr && (reg_addr == 3'd1);

    assert_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !irq) |=> !irq);

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && en && flt_valid) |=> (irq && rec.addr == $past(flt_addr)));

    assert_hold_log_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_w) |=> (irq && $stable(rec)));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf == MAXV && !ack_w) |=> (ovf == MAXV));

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_w |=> (ovf == '0));

    assert_ack_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_w && en && flt_valid) |=> (irq && rec.addr == $past(flt_addr)));
endmodule

bind dma_fault_logger dfl_checker #(.OVF_W(OVF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .irq(irq), .en(en_q),
    .ovf(ovf_cnt), .rec(rec_q)
);

// File: tb/dma_fault_logger_bench.sv
`timescale 1ns/1ps
module dma_fault_logger_bench;
    localparam int OVF_W = 8;
    localparam int OVF_MAX = (1 << OVF_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_valid = 1'b0;
    logic [7:0]  flt_code = '0;
    logic [15:0] flt_src = '0;
    logic [47:0] flt_addr = '0;
    logic [9:0]  flt_bytes = '0;
    logic [11:0] flt_route = '0;
    logic [7:0]  flt_priv = '0;
    logic [5:0]  flt_props = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;

    // model state
    bit          m_en, m_held;
    int          m_ovf;
    logic [7:0]  m_code;
    logic [15:0] m_src;
    logic [47:0] m_addr;
    logic [9:0]  m_bytes;
    logic [11:0] m_route;
    logic [7:0]  m_priv;
    logic [5:0]  m_props;

    always #2 clk = ~clk;

    dma_fault_logger #(.OVF_W(OVF_W)) u_dma_fault_logger (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_code(flt_code),
        .flt_src(flt_src), .flt_addr(flt_addr), .flt_bytes(flt_bytes),
        .flt_route(flt_route), .flt_priv(flt_priv), .flt_props(flt_props),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_reg(input int a);
        logic [31:0] v = '0;
        case (a)
            0: v[0] = m_en;
            2: v = {8'h0, m_code, m_src};
            3: v = m_addr[31:0];
            4: v = {16'h0, m_addr[47:32]};
            5: v = {4'h0, m_route, m_priv, 2'b00, m_props};
            6: v = {22'h0, m_bytes};
            7: begin v[0] = m_held; v[16 +: OVF_W] = m_ovf[OVF_W-1:0]; end
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string req_of(input int a);
        case (a)
            0: return "R2";
            1: return "R8";
            7: return "R5";
            default: return "R3";
        endcase
    endfunction

    // model update from the stimulus sampled at this edge
    function automatic void model_step();
        bit ack = reg_wr && reg_addr == 3'd1;
        bit take = flt_valid && m_en && (!m_held || ack);
        bit lose = flt_valid && m_en && m_held && !ack;
        if (ack) begin m_held = 0; m_ovf = 0; end
        if (lose && m_ovf < OVF_MAX) m_ovf++;
        if (take) begin
            m_held = 1; m_code = flt_code; m_src = flt_src; m_addr = flt_addr;
            m_bytes = flt_bytes; m_route = flt_route; m_priv = flt_priv;
            m_props = flt_props;
        end
        if (reg_wr && reg_addr == 3'd0) m_en = reg_wdata[0];
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp,
                       input string req, input string what);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        reg_wr = 0; flt_valid = 0;
        for (int a = 0; a < 8; a++) begin
            reg_addr = a[2:0];
            #0.1;
            chk(reg_rdata, exp_reg(a), (tag != "") ? tag : req_of(a),
                $sformatf("reg %0d", a));
        end
        chk({31'h0, irq}, {31'h0, m_held}, (tag != "") ? tag : "R6", "irq");
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic set_fault();
        flt_valid = 1;
        flt_code  = 8'($urandom_range(0, 7));
        flt_src   = 16'($urandom);
        flt_addr  = {16'($urandom), 32'($urandom)};
        flt_bytes = 10'($urandom);
        flt_route = 12'($urandom);
        flt_priv  = 8'($urandom);
        flt_props = 6'($urandom);
    endtask

    task automatic set_write(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_en = 0; m_held = 0; m_ovf = 0;
        m_code = '0; m_src = '0; m_addr = '0; m_bytes = '0;
        m_route = '0; m_priv = '0; m_props = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check_all("R1");

        // fault while disabled: ignored (R2)
        set_fault(); cycle("R2");
        set_fault(); cycle("R2");
        set_write(3'd0, 32'h1); cycle("R2");

        // first capture, code 0 = miss (R3)
        set_fault(); flt_code = 8'd0; cycle("R3");
        // later fault keeps log, counted (R4)
        set_fault(); flt_code = 8'd6; cycle("R4");
        // read-only writes ignored (R8)
        set_write(3'd3, 32'hffff_ffff); cycle("R8");
        set_write(3'd7, 32'hffff_ffff); cycle("R8");
        // acknowledge (R6)
        set_write(3'd1, 32'h0); cycle("R6");
        // capture with prefetch code, then ack with a fault in the same cycle (R7)
        set_fault(); flt_code = 8'd6; cycle("R3");
        set_fault(); cycle("R5");
        set_fault(); set_write(3'd1, 32'h0); cycle("R7");

        // saturation of the drop count (R5)
        for (int i = 0; i < OVF_MAX + 8; i++) begin
            set_fault(); cycle("R5");
        end
        set_write(3'd1, 32'h0); cycle("R6");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 1) == 1) set_fault();
            if ($urandom_range(0, 99) < 15) begin
                case ($urandom_range(0, 3))
                    0: set_write(3'd0, (($urandom_range(0, 9) == 0) ? 32'h0 : 32'h1));
                    1, 2: set_write(3'd1, $urandom);
                    default: set_write(3'($urandom_range(2, 7)), $urandom);
                endcase
            end
            cycle("");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule